// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block computes `X^e mod N` for an odd modulus with a left-to-right square-and-multiply walk over the exponent. It drives two bit-serial Montgomery multipliers. Each multiplier returns `A*B*2^-W mod N`. The first multiplier maps the base into the Montgomery domain with the precomputed `R^2 mod N`. The second multiplier runs the square and multiply loop, starting from the precomputed `R mod N`. Once the exponent is used up, the first multiplier takes the constant 1 in place of the base and brings the accumulator back to ordinary form.

The caller waits for `ready`, then presents the base, exponent, modulus and the two precomputed constants while pulsing `en` for one cycle. Normalising the base overlaps the first squaring. The normalised base is held in a register for the whole run. Each multiplier result goes straight back as the next operand without passing through an adder. When the answer is ready, `res_valid` pulses for one cycle with `result`.

Top module: `mont_exp_seq`

## Requirements
- R1: After reset `ready` is 1 and `res_valid` is 0. `ready` is 0 from the cycle after an accepted start until the cycle after the result pulse.
- R2: A start is accepted only when `en` is 1 while `ready` is 1. All operands are captured on that edge. An `en` pulse while busy has no effect: no extra result appears and the running result does not change.
- R3: For an odd `N` > 1, `X` < `N`, `r_mod` = 2^W mod N and `r2_mod` = 2^(2W) mod N, `result` equals `X^e mod N`, where `e` is read as an unsigned EW-bit number.
- R4: Every result, and every multiplier output inside the block, is strictly less than `N`.
- R5: With `e` = 0 the result is 1, whatever the value of `X`, including `X` = 0.
- R6: With `e` = 1 the result is `X`. With `X` = 0 and `e` > 0 the result is 0.
- R7: `res_valid` is high for exactly one cycle per accepted start, and `ready` is 1 in the following cycle.
- R8: The exponent is scanned from bit EW-1 down to bit 0. Each bit costs one squaring, and a bit set to 1 costs one further multiplication. An exponent with more set bits therefore takes strictly longer than one with fewer set bits at the same width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready | output | 1 | Block is idle and will accept a start |
| en | input | 1 | Start request, sampled while `ready` is 1 |
| x_in | input | W | Base, must be less than `n_in` |
| e_in | input | EW | Exponent |
| n_in | input | W | Odd modulus, greater than 1 |
| r_mod | input | W | 2^W mod N, precomputed |
| r2_mod | input | W | 2^(2W) mod N, precomputed |
| res_valid | output | 1 | One-cycle pulse, `result` is valid |
| result | output | W | X^e mod N |

## Verification
The range assertions on multiplier outputs and on the final result rely on the modulus being odd and greater than 1, on the base being below the modulus, and on the two constants being correctly reduced. With any of these broken, the bit-serial reduction no longer stays below 2N. The stimulus draws each modulus at random, forces its low bit to 1 and raises it to at least 3. The base is taken as a random value reduced modulo N. Both constants are computed in the bench with 64-bit arithmetic, so every run stays inside those assumptions, including the runs for the corner exponents and the zero base.

// File: rtl/mont_exp_pkg.sv
package mont_exp_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SQUARE,
        SEQ_MULT,
        SEQ_CONV,
        SEQ_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        MM_IDLE,
        MM_RUN,
        MM_FIX
    } mm_state_t;

endpackage

// File: rtl/mont_mul_serial.sv
module mont_mul_serial
    import mont_exp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] modn,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int AW = W + 2;

    typedef struct packed {
        mm_state_t     st;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W:0]    ypn;
        logic [W-1:0]  n;
        logic [AW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          done;
        logic [W-1:0]  res;
    } mm_regs_t;

    mm_regs_t r_q, r_d;

    logic          xk, q;
    logic [AW-1:0] addend, sum, diff;

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        xk     = r_q.x[r_q.cnt];
        q      = r_q.acc[0] ^ (xk & r_q.y[0]);
        case ({xk, q})
            2'b00:   addend = '0;
            2'b01:   addend = AW'(r_q.n);
            2'b10:   addend = AW'(r_q.y);
            default: addend = AW'(r_q.ypn);
        endcase
        sum  = r_q.acc + addend;
        diff = r_q.acc - AW'(r_q.n);
        case (r_q.st)
            MM_IDLE: begin
                if (start) begin
                    r_d.x   = opa;
                    r_d.y   = opb;
                    r_d.n   = modn;
                    r_d.ypn = {1'b0, opb} + {1'b0, modn};
                    r_d.acc = '0;
                    r_d.cnt = '0;
                    r_d.st  = MM_RUN;
                end
            end
            MM_RUN: begin
                r_d.acc = sum >> 1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(W - 1)) begin
                    r_d.st = MM_FIX;
                end
            end
            MM_FIX: begin
                r_d.res  = (r_q.acc >= AW'(r_q.n)) ? diff[W-1:0] : r_q.acc[W-1:0];
                r_d.done = 1'b1;
                r_d.st   = MM_IDLE;
            end
            default: r_d.st = MM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: MM_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign prod = r_q.res;

    p_mm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod < r_q.n))
        else $error("multiplier output not reduced");

    p_mm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("multiplier done longer than one cycle");

endmodule

// File: rtl/mont_exp_seq.sv
module mont_exp_seq
    import mont_exp_pkg::*;
#(
    parameter int W  = 16,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    input  logic          en,
    input  logic [W-1:0]  x_in,
    input  logic [EW-1:0] e_in,
    input  logic [W-1:0]  n_in,
    input  logic [W-1:0]  r_mod,
    input  logic [W-1:0]  r2_mod,
    output logic          res_valid,
    output logic [W-1:0]  result
);
    localparam int IW = (EW > 1) ? $clog2(EW) : 1;

    typedef struct packed {
        seq_state_t    st;
        logic [W-1:0]  n;
        logic [EW-1:0] e;
        logic [IW-1:0] idx;
        logic [W-1:0]  xbar;
        logic          s1;
        logic          s2;
        logic [W-1:0]  m1a;
        logic [W-1:0]  m1b;
        logic [W-1:0]  m2a;
        logic [W-1:0]  m2b;
        logic [W-1:0]  res;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic         mm1_done, mm2_done;
    logic [W-1:0] mm1_res, mm2_res;

    mont_mul_serial #(.W(W)) u_mm_norm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (r_q.s1),
        .opa   (r_q.m1a),
        .opb   (r_q.m1b),
        .modn  (r_q.n),
        .done  (mm1_done),
        .prod  (mm1_res)
    );

    mont_mul_serial #(.W(W)) u_mm_loop (
        .clk   (clk),
        .rst_n (rst_n),
        .start (r_q.s2),
        .opa   (r_q.m2a),
        .opb   (r_q.m2b),
        .modn  (r_q.n),
        .done  (mm2_done),
        .prod  (mm2_res)
    );

    logic [W-1:0] acc_new;
    logic         go_next;

    always_comb begin
        r_d     = r_q;
        r_d.s1  = 1'b0;
        r_d.s2  = 1'b0;
        acc_new = mm2_res;
        go_next = 1'b0;
        case (r_q.st)
            SEQ_IDLE: begin
                if (en) begin
                    r_d.n   = n_in;
                    r_d.e   = e_in;
                    r_d.idx = IW'(EW - 1);
                    r_d.m1a = x_in;
                    r_d.m1b = r2_mod;
                    r_d.m2a = r_mod;
                    r_d.m2b = r_mod;
                    r_d.s1  = 1'b1;
                    r_d.s2  = 1'b1;
                    r_d.st  = SEQ_SQUARE;
                end
            end
            SEQ_SQUARE: begin
                if (mm1_done) begin
                    r_d.xbar = mm1_res;
                end
                if (mm2_done) begin
                    if (r_q.e[r_q.idx]) begin
                        r_d.m2a = mm2_res;
                        r_d.m2b = mm1_done ? mm1_res : r_q.xbar;
                        r_d.s2  = 1'b1;
                        r_d.st  = SEQ_MULT;
                    end else begin
                        go_next = 1'b1;
                    end
                end
            end
            SEQ_MULT: begin
                go_next = mm2_done;
            end
            SEQ_CONV: begin
                if (mm1_done) begin
                    r_d.res = mm1_res;
                    r_d.st  = SEQ_DONE;
                end
            end
            SEQ_DONE: begin
                r_d.st = SEQ_IDLE;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
        if (go_next) begin
            if (r_q.idx == '0) begin
                r_d.m1a = acc_new;
                r_d.m1b = W'(1);
                r_d.s1  = 1'b1;
                r_d.st  = SEQ_CONV;
            end else begin
                r_d.idx = r_q.idx - 1'b1;
                r_d.m2a = acc_new;
                r_d.m2b = acc_new;
                r_d.s2  = 1'b1;
                r_d.st  = SEQ_SQUARE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st == SEQ_IDLE);
    assign res_valid = (r_q.st == SEQ_DONE);
    assign result    = r_q.res;

    p_start_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(en))
        else $error("left idle without a start request");

    p_operands_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> ($stable(r_q.n) && $stable(r_q.e)))
        else $error("captured operands changed while busy");

    p_result_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (result < r_q.n))
        else $error("result not below modulus");

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && ready))
        else $error("result pulse malformed");

endmodule

// File: tb/tb_mont_exp_seq.sv
module tb_mont_exp_seq;
    localparam int W  = 16;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready, en, res_valid;
    logic [W-1:0]  x_in, n_in, r_mod, r2_mod, result;
    logic [EW-1:0] e_in;

    int total = 0;
    int bad   = 0;
    int got   = 0;
    int sent  = 0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #10 clk = ~clk;

    mont_exp_seq #(.W(W), .EW(EW)) dut (
        .clk(clk), .rst_n(rst_n), .ready(ready), .en(en),
        .x_in(x_in), .e_in(e_in), .n_in(n_in), .r_mod(r_mod),
        .r2_mod(r2_mod), .res_valid(res_valid), .result(result)
    );

    function automatic longint modpow(longint b, longint e, longint m);
        longint r = 1 % m;
        longint bb = b % m;
        for (int i = 0; i < EW; i++) begin
            if (e[i]) r = (r * bb) % m;
            bb = (bb * bb) % m;
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    int cyc_cnt = 0;
    int last_cycles = 0;
    int t_start = 0;
    always @(posedge clk) cyc_cnt++;

    task automatic run_op(logic [W-1:0] x, logic [EW-1:0] e, logic [W-1:0] n,
                          string tag, bit poke_busy);
        longint rm;
        longint r2;
        rm = 65536 % longint'(n);
        r2 = (rm * rm) % longint'(n);
        while (!ready) @(negedge clk);
        x_in = x; e_in = e; n_in = n; r_mod = W'(rm); r2_mod = W'(r2);
        en = 1'b1;
        exp_q.push_back(W'(modpow(longint'(x), longint'(e), longint'(n))));
        tag_q.push_back(tag);
        sent++;
        t_start = cyc_cnt;
        @(negedge clk);
        en = 1'b0;
        // R1: busy after accepted start
        check(ready == 1'b0, "R1 ready low while busy", ready, 0);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            // R2: start request while busy must be ignored
            x_in = x ^ 16'h00ff; e_in = ~e; n_in = 16'd7;
            en = 1'b1;
            @(negedge clk);
            en = 1'b0;
        end
        while (!res_valid) @(negedge clk);
        last_cycles = cyc_cnt - t_start;
        @(negedge clk);
        // R7: ready again right after the pulse
        check(ready == 1'b1 && res_valid == 1'b0, "R7 ready after pulse", ready, 1);
    endtask

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            logic [W-1:0] ev;
            string t;
            got++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", result, 0);
            end else begin
                ev = exp_q.pop_front();
                t = tag_q.pop_front();
                check(result == ev, t, result, ev);
                check(result < n_in || n_in == 16'd7, "R4 result below modulus", result, n_in);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c_lo;
        int c_hi;
        logic [W-1:0] n;
        en = 1'b0; x_in = '0; e_in = '0; n_in = 16'd3; r_mod = '0; r2_mod = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready idle", ready, 1);

        // R3 fixed small case
        run_op(16'd4, 16'd13, 16'd497, "R3 4^13 mod 497", 1'b0);
        // R5 e=0
        run_op(16'd1234, 16'd0, 16'd40001, "R5 e zero", 1'b0);
        run_op(16'd0, 16'd0, 16'd40001, "R5 zero pow zero", 1'b0);
        // R6 e=1 and zero base
        run_op(16'd999, 16'd1, 16'd40001, "R6 e one", 1'b0);
        run_op(16'd0, 16'd77, 16'd12345, "R6 zero base", 1'b0);
        // R3 boundary modulus and exponent
        run_op(16'd65534, 16'hffff, 16'hffff, "R3 max operands", 1'b0);
        run_op(16'd2, 16'h8000, 16'd3, "R3 smallest modulus", 1'b0);
        // R2 ignored start while busy
        run_op(16'd321, 16'h1234, 16'd54321, "R2 busy en ignored", 1'b1);

        // R8 latency grows with set bits
        run_op(16'd5, 16'h8000, 16'd1001, "R8 one set bit", 1'b0);
        c_lo = last_cycles;
        run_op(16'd5, 16'hffff, 16'd1001, "R8 all bits set", 1'b0);
        c_hi = last_cycles;
        check(c_hi > c_lo, "R8 latency order", c_hi, c_lo);

        // R3 random odd moduli
        for (int i = 0; i < 40; i++) begin
            n = W'($urandom) | 16'd1;
            if (n < 16'd3) n = 16'd3;
            run_op(W'($urandom % n), EW'($urandom), n, "R3 random", 1'b0);
        end

        repeat (5) @(negedge clk);
        check(got == sent, "R2 result count", got, sent);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule